// File: doc/BRIEF.md
# Next-PC and Link Unit

This block works out where instruction fetch goes next in a 32-bit load/store core whose instructions are all 32 bits wide. It takes the current program counter, the instruction just fetched, a flag that says whether the two source registers hold equal values, and a register value to use for indirect jumps. From these it produces the next program counter. It also reports whether the instruction took a control transfer and whether a link register write is needed, along with the value to write.

The block is purely combinational. Register reads, the equality compare and any pipeline staging are done by the logic around it. Opcode field positions follow the usual layout: the major opcode is in bits 31:26, the function code is in bits 5:0, the branch offset is in bits 15:0 and the jump index is in bits 25:0.

Top module: `npc_link_unit`

## Requirements
- R1: For any instruction that is not a control transfer, next_pc_o is pc_i + 4, redirect_o is 0 and link_we_o is 0. This includes opcode 0 with a function code other than 8.
- R2: Opcode 4 (branch if equal) with ops_equal_i = 1 gives next_pc_o = pc_i + 4 + (sign-extended bits 15:0 × 4) and redirect_o = 1.
- R3: Opcode 5 (branch if not equal) with ops_equal_i = 0 gives the same target as R2 and redirect_o = 1.
- R4: A branch whose condition fails (opcode 4 with ops_equal_i = 0, or opcode 5 with ops_equal_i = 1) gives next_pc_o = pc_i + 4 and redirect_o = 0.
- R5: A branch offset with bit 15 set moves the target backwards. For example, offset 0xFFFF gives pc_i + 4 − 4 = pc_i.
- R6: Opcode 2 (jump) gives next_pc_o = {bits 31:28 of pc_i + 4, bits 25:0 of the instruction, 2'b00} and redirect_o = 1. The upper bits come from pc_i + 4, not from pc_i.
- R7: Opcode 3 (jump and link) jumps to the same target as R6, sets link_we_o = 1 and sets link_data_o = pc_i + 4. No other opcode sets link_we_o.
- R8: Opcode 0 with function code 8 (register jump) gives next_pc_o = jr_value_i and redirect_o = 1, and does not write the link register.
- R9: link_idx_o is always 31.
- R10: pc_i + 4 wraps modulo 2^32, so pc_i = 0xFFFFFFFC falls through to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Fetched instruction word |
| ops_equal_i | input | 1 | 1 when the two compared registers are equal |
| jr_value_i | input | 32 | Register value used as the target of a register jump |
| next_pc_o | output | 32 | Next program counter |
| redirect_o | output | 1 | 1 when a control transfer is taken |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Index of the link register (constant 31) |
| link_data_o | output | 32 | Value for the link register (pc_i + 4) |

## Verification
The bench targets these corner cases:

- **Sign of the branch offset.** An offset of 0xFFFF and the largest negative offset would point forward if the design zero-extended the offset.
- **Polarity of the equality flag.** If it were inverted for one of the two branch opcodes, a taken branch would fall through and an untaken one would redirect.
- **Jump region.** The test uses a PC such as 0x0FFFFFFC, where pc_i and pc_i + 4 have different top nibbles. A design that takes the region from pc_i would jump into the wrong 256 MB segment.
- **Opcode 0 function codes.** Function codes other than 8 are applied to show that only the register jump redirects. Plain jumps are mixed with jump-and-link to catch a link write that leaks onto the wrong opcode.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned OFS_W   = 16;
  localparam int unsigned IDX_W   = 26;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned ILEN_B  = 4;
  localparam int unsigned ALIGN_W = 2;
  localparam int unsigned REGION_W = XLEN - IDX_W - ALIGN_W;

  localparam logic [OPC_W-1:0]  OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0]  OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0]  OPC_JLINK   = 6'd3;
  localparam logic [OPC_W-1:0]  OPC_BREQ    = 6'd4;
  localparam logic [OPC_W-1:0]  OPC_BRNE    = 6'd5;
  localparam logic [FN_W-1:0]   FN_REGJUMP  = 6'd8;
  localparam logic [RIDX_W-1:0] LINK_REG    = 5'd31;

  typedef enum logic [2:0] {
    XFER_SEQ,
    XFER_BREQ,
    XFER_BRNE,
    XFER_JUMP,
    XFER_JLINK,
    XFER_REGJ
  } xfer_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  output xfer_kind_e       kind_o
);
  always_comb begin
    unique case (opc_i)
      OPC_BREQ:    kind_o = XFER_BREQ;
      OPC_BRNE:    kind_o = XFER_BRNE;
      OPC_JUMP:    kind_o = XFER_JUMP;
      OPC_JLINK:   kind_o = XFER_JLINK;
      OPC_SPECIAL: kind_o = (fn_i == FN_REGJUMP) ? XFER_REGJ : XFER_SEQ;
      default:     kind_o = XFER_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  logic [AW-1:0]    pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    seq_pc_o,
  output logic [AW-1:0]    br_pc_o,
  output logic [AW-1:0]    jmp_pc_o
);
  localparam int unsigned SEXT_W = AW - OFS_W - ALIGN_W;
  localparam int unsigned RGN_W  = AW - IDX_W - ALIGN_W;

  logic [AW-1:0] ofs_bytes;

  always_comb begin
    seq_pc_o  = pc_i + AW'(ILEN_B);
    ofs_bytes = {{SEXT_W{ofs_i[OFS_W-1]}}, ofs_i, {ALIGN_W{1'b0}}};
    br_pc_o   = seq_pc_o + ofs_bytes;
    jmp_pc_o  = {seq_pc_o[AW-1 -: RGN_W], idx_i, {ALIGN_W{1'b0}}};
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  xfer_kind_e    kind_i,
  input  logic          eq_i,
  input  logic [AW-1:0] seq_pc_i,
  input  logic [AW-1:0] br_pc_i,
  input  logic [AW-1:0] jmp_pc_i,
  input  logic [AW-1:0] reg_pc_i,
  output logic [AW-1:0] next_pc_o,
  output logic          taken_o,
  output logic          link_o
);
  always_comb begin
    taken_o = 1'b0;
    link_o  = 1'b0;
    unique case (kind_i)
      XFER_BREQ:  taken_o = eq_i;
      XFER_BRNE:  taken_o = ~eq_i;
      XFER_JUMP:  taken_o = 1'b1;
      XFER_JLINK: begin taken_o = 1'b1; link_o = 1'b1; end
      XFER_REGJ:  taken_o = 1'b1;
      default:    taken_o = 1'b0;
    endcase
  end

  always_comb begin
    next_pc_o = seq_pc_i;
    if (taken_o) begin
      unique case (kind_i)
        XFER_BREQ, XFER_BRNE:  next_pc_o = br_pc_i;
        XFER_JUMP, XFER_JLINK: next_pc_o = jmp_pc_i;
        XFER_REGJ:             next_pc_o = reg_pc_i;
        default:               next_pc_o = seq_pc_i;
      endcase
    end
  end
endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit
  import npc_pkg::*;
(
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic        ops_equal_i,
  input  logic [31:0] jr_value_i,
  output logic [31:0] next_pc_o,
  output logic        redirect_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_data_o
);
  xfer_kind_e        kind;
  logic [XLEN-1:0]   seq_pc;
  logic [XLEN-1:0]   br_pc;
  logic [XLEN-1:0]   jmp_pc;

  npc_decode u_dec (
    .opc_i  (instr_i[XLEN-1 -: OPC_W]),
    .fn_i   (instr_i[FN_W-1:0]),
    .kind_o (kind)
  );

  npc_target #(.AW(XLEN)) u_tgt (
    .pc_i     (pc_i),
    .ofs_i    (instr_i[OFS_W-1:0]),
    .idx_i    (instr_i[IDX_W-1:0]),
    .seq_pc_o (seq_pc),
    .br_pc_o  (br_pc),
    .jmp_pc_o (jmp_pc)
  );

  npc_select #(.AW(XLEN)) u_sel (
    .kind_i    (kind),
    .eq_i      (ops_equal_i),
    .seq_pc_i  (seq_pc),
    .br_pc_i   (br_pc),
    .jmp_pc_i  (jmp_pc),
    .reg_pc_i  (jr_value_i),
    .next_pc_o (next_pc_o),
    .taken_o   (redirect_o),
    .link_o    (link_we_o)
  );

  assign link_idx_o  = LINK_REG;
  assign link_data_o = seq_pc;
endmodule

// File: rtl/npc_link_unit_chk.sv
module npc_link_unit_chk (
  input logic [31:0] pc_i,
  input logic [5:0]  opc_i,
  input logic [31:0] jr_value_i,
  input logic [31:0] next_pc_o,
  input logic        redirect_o,
  input logic        link_we_o,
  input logic [4:0]  link_idx_o,
  input logic [31:0] link_data_o
);
  logic [31:0] step;
  assign step = pc_i + 32'd4;

  always_comb begin
    if (!redirect_o)
      assert_seq_fallthrough_R1: assert (next_pc_o == step);
    if (link_we_o)
      assert_link_value_R7: assert (redirect_o && link_data_o == step && opc_i == 6'd3);
    if (redirect_o && (opc_i == 6'd2 || opc_i == 6'd3))
      assert_jump_region_R6: assert (next_pc_o[31:28] == step[31:28] && next_pc_o[1:0] == 2'b00);
    if (redirect_o && opc_i == 6'd0)
      assert_regjump_target_R8: assert (next_pc_o == jr_value_i && !link_we_o);
    assert_link_index_R9: assert (link_idx_o == 5'd31);
  end
endmodule

bind npc_link_unit npc_link_unit_chk u_chk (
  .pc_i        (pc_i),
  .opc_i       (instr_i[31:26]),
  .jr_value_i  (jr_value_i),
  .next_pc_o   (next_pc_o),
  .redirect_o  (redirect_o),
  .link_we_o   (link_we_o),
  .link_idx_o  (link_idx_o),
  .link_data_o (link_data_o)
);

// File: tb/sim_npc_link_unit.sv
module sim_npc_link_unit;
  logic clk;
  logic rst_n;
  logic [31:0] pc_i, instr_i, jr_value_i;
  logic        ops_equal_i;
  logic [31:0] next_pc_o, link_data_o;
  logic        redirect_o, link_we_o;
  logic [4:0]  link_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  npc_link_unit u0 (
    .pc_i(pc_i), .instr_i(instr_i), .ops_equal_i(ops_equal_i),
    .jr_value_i(jr_value_i), .next_pc_o(next_pc_o), .redirect_o(redirect_o),
    .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_data_o(link_data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk(int op, logic [25:0] body);
    return {op[5:0], body};
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: apply inputs after a rising edge, compare at the falling edge
  task automatic step(string tag, logic [31:0] pc, logic [31:0] ins, logic eq, logic [31:0] jv);
    int op, fn;
    longint ofs;
    logic [31:0] seq, e_next;
    bit e_red, e_link;
    @(posedge clk); #1;
    pc_i = pc; instr_i = ins; ops_equal_i = eq; jr_value_i = jv;
    op  = int'(ins >> 26);
    fn  = int'(ins & 32'h3F);
    ofs = longint'($signed(ins[15:0])) * 4;
    seq = pc + 32'd4;
    e_next = seq; e_red = 0; e_link = 0;
    if ((op == 4 && eq) || (op == 5 && !eq)) begin
      e_red = 1; e_next = 32'(longint'(seq) + ofs);
    end else if (op == 2 || op == 3) begin
      e_red = 1; e_next = (seq & 32'hF000_0000) | ((ins & 32'h03FF_FFFF) << 2);
      e_link = (op == 3);
    end else if (op == 0 && fn == 8) begin
      e_red = 1; e_next = jv;
    end
    @(negedge clk);
    cmp(tag, "next_pc", next_pc_o, e_next);
    cmp(tag, "redirect", {31'd0, redirect_o}, {31'd0, e_red});
    cmp(tag, "link_we", {31'd0, link_we_o}, {31'd0, e_link});
    cmp("R9", "link_idx", {27'd0, link_idx_o}, 32'd31);
    if (e_link) cmp(tag, "link_data", link_data_o, seq);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pc_i = '0; instr_i = '0; ops_equal_i = 1'b0; jr_value_i = '0;
    @(negedge clk);
    // Reset state: idle inputs fall through
    cmp("R1", "reset next_pc", next_pc_o, 32'd4);
    cmp("R1", "reset redirect", {31'd0, redirect_o}, 32'd0);
    cmp("R9", "reset link_idx", {27'd0, link_idx_o}, 32'd31);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    step("R1", 32'h0000_1000, mk(8, 26'h00A_0005), 1'b1, 32'h0);       // add-immediate type
    step("R1", 32'h0000_1000, mk(0, 26'h0000_020), 1'b0, 32'h1234_5678); // funct 32
    step("R1", 32'h0000_1000, mk(0, 26'h3E0_0009), 1'b0, 32'h1234_5678); // funct 9
    step("R2", 32'h0000_2000, mk(4, 26'h022_0019), 1'b1, 32'h0);
    step("R4", 32'h0000_2000, mk(4, 26'h022_0019), 1'b0, 32'h0);
    step("R3", 32'h0000_3000, mk(5, 26'h022_0040), 1'b0, 32'h0);
    step("R4", 32'h0000_3000, mk(5, 26'h022_0040), 1'b1, 32'h0);
    step("R5", 32'h0000_4000, mk(4, 26'h000_FFFF), 1'b1, 32'h0);
    step("R5", 32'h0004_0000, mk(5, 26'h000_8000), 1'b0, 32'h0);
    step("R5", 32'h0000_0010, mk(4, 26'h000_FFF0), 1'b1, 32'h0);
    step("R6", 32'h4000_0000, mk(2, 26'd2500), 1'b0, 32'h0);
    step("R6", 32'h0FFF_FFFC, mk(2, 26'h3FF_FFFF), 1'b0, 32'h0);
    step("R7", 32'h8000_0100, mk(3, 26'd2500), 1'b1, 32'h0);
    step("R7", 32'h0FFF_FFFC, mk(3, 26'h000_0001), 1'b0, 32'h0);
    step("R8", 32'h0000_5000, mk(0, 26'h3E0_0008), 1'b0, 32'hDEAD_BEE0);
    step("R8", 32'hFFFF_FFFC, mk(0, 26'h020_0008), 1'b1, 32'h0000_0040);
    step("R10", 32'hFFFF_FFFC, mk(35, 26'h022_0064), 1'b0, 32'h0);
    step("R10", 32'hFFFF_FFFC, mk(4, 26'h000_0002), 1'b1, 32'h0);

    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] body;
      op = int'($urandom_range(0, 9));
      body = $urandom;
      if (op == 0 && ($urandom_range(0, 1) == 1)) body[5:0] = 6'd8;
      step((op == 0) ? "R8" : (op == 2) ? "R6" : (op == 3) ? "R7" :
           (op == 4) ? "R2" : (op == 5) ? "R3" : "R1",
           {$urandom} & 32'hFFFF_FFFC, mk(op, body[25:0]),
           1'($urandom_range(0, 1)), $urandom);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule